// File: doc/BRIEF.md
# Parallel Channel Device Responder

This block sits on the peripheral side of a parallel channel and answers transfer cycles that a channel master starts. The master drives an address, a direction and (for output cycles) data, and then pulls the active-low cycle strobe. The block samples the strobe on its own clock. On the first clock where the strobe is active, it compares the address with its parameterised device address and records the result for the rest of the cycle.

When the address matches, the block pulls the shared open-drain ready line low straight away. It keeps the line low until its local logic has dealt with the transfer, so a slow local side makes the master insert wait states. On an output cycle, the falling edge of the active-low data strobe captures the bus data. The block then offers the data locally with `wr_valid` until `ack` arrives. On an input cycle, the block raises `rd_req`, drives the bus from its data holding register, and captures `rd_data` when `ack` arrives. The ready line is released on the same clock edge that puts the new data on the bus. A cycle with a different address leaves every output of the block released.

Top module: `pcr_device_responder`

## Requirements
- R1: The address is compared with `DEV_ADDR` only on the first clock where `cyc_n` is sampled low. When it differs, `rdy_pull`, `dout_oe`, `wr_valid` and `rd_req` all stay 0 for the whole cycle.
- R2: For a matched cycle, `rdy_pull` is 1 from the clock after `cyc_n` is first sampled low. The line is always driven within `READY_BUDGET` clocks, which is the 625 ns budget (`READY_NS`) divided by `CLK_NS` and rounded up (32 for 625 and 20).
- R3: In a matched cycle, `rdy_pull` falls to 0 one clock after `ack` is sampled while a request is pending. It then stays 0 until `cyc_n` goes high.
- R4: In a matched output cycle (`is_read`=0), the first falling edge of `dstrb_n` that is sampled captures `bus_din` into `wr_data` and sets `wr_valid` on the next clock. `wr_valid` stays set until `ack`. Later data strobes in the same cycle do not change `wr_data`.
- R5: In a matched input cycle (`is_read`=1), `rd_req` is 1 until `ack`. The clock that samples `ack` loads `rd_data` into `bus_dout`, and the same clock releases `rdy_pull`.
- R6: `dout_oe` is 1 only while the block is in a matched input cycle and `cyc_n` is low. When `cyc_n` goes high, `dout_oe`, `rdy_pull` and `rd_req` drop to 0 combinationally. After reset all four outputs are 0.
- R7: An `ack` sampled while no request is pending has no effect, and `rdy_pull` stays 1.
- R8: Address changes after the first clock of the strobe have no effect on whether the block responds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_n | input | 1 | Cycle strobe from the master, active low |
| dstrb_n | input | 1 | Output data strobe, active low |
| is_read | input | 1 | 1 = input cycle (device supplies data), 0 = output cycle |
| bus_addr | input | AW | Address driven by the master |
| bus_din | input | DW | Data driven by the master |
| bus_dout | output | DW | Data toward the master for input cycles |
| dout_oe | output | 1 | Drive enable for `bus_dout` |
| rdy_pull | output | 1 | 1 = pull the open-drain ready line low (not ready) |
| wr_valid | output | 1 | Captured write data is waiting for the local side |
| wr_data | output | DW | Captured write data |
| rd_req | output | 1 | Local side is asked for read data |
| rd_data | input | DW | Read data from the local side |
| ack | input | 1 | Local side accepts or supplies data |

## Verification
Every one of the 256 addresses is tried with an output cycle and with an input cycle. This shows that exactly one address makes the block respond, and that all others leave the bus released. The number of wait states before `ack` changes from address to address, which separates ready timing that really follows the local handshake from timing fixed to the strobe. Each cycle also changes the bus data after capture, moves the address to or away from the device address in mid-cycle, sends an `ack` before anything is pending, and repeats the data strobe. Together these expose latching at the wrong time, address decoding after the first clock, and an `ack` that is not qualified by a pending request.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } xfer_dir_e;

  // Match test on zero-extended addresses.
  function automatic logic addr_hit(input logic [31:0] a, input logic [31:0] dev);
    return a == dev;
  endfunction

  // Clocks available inside a time budget, rounded up.
  function automatic int budget_clocks(input int budget_ns, input int clk_ns);
    return (budget_ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/pcr_wr_latch.sv
module pcr_wr_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_n,
  input  logic          dstrb_n,
  input  logic          take_en,
  input  logic          ack,
  input  logic [DW-1:0] bus_din,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data
);

  logic dstrb_q;
  logic dstrb_fall;
  logic captured;

  assign dstrb_fall = ~dstrb_n & ~dstrb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dstrb_q  <= 1'b0;
      captured <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      dstrb_q <= ~dstrb_n;
      if (cyc_n) begin
        captured <= 1'b0;
        wr_valid <= 1'b0;
      end else if (take_en && dstrb_fall && !captured) begin
        captured <= 1'b1;
        wr_valid <= 1'b1;
        wr_data  <= bus_din;
      end else if (wr_valid && ack) begin
        wr_valid <= 1'b0;
      end
    end
  end

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_n && take_en && dstrb_fall && !captured) |=> (wr_valid && wr_data == $past(bus_din)));

  assert_hold_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && !cyc_n) |=> $stable(wr_data));

endmodule

// File: rtl/pcr_rd_hold.sv
module pcr_rd_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= rd_data;
  end

  assert_read_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (q == $past(rd_data)));

endmodule

// File: rtl/pcr_cycle_ctl.sv
module pcr_cycle_ctl
  import pcr_pkg::*;
#(
  parameter int BUDGET = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_n,
  input  logic match_now,
  input  logic is_read,
  input  logic wr_valid,
  input  logic ack,
  output logic hit,
  output logic rd_dir,
  output logic rdy_pull,
  output logic dout_oe,
  output logic rd_req,
  output logic rd_take,
  output logic wr_side_en
);

  localparam int CW = $clog2(BUDGET + 2);

  logic      strb_q;
  logic      start;
  logic      done;
  xfer_dir_e dir;
  logic      wr_take;
  logic [CW-1:0] late_cnt;

  assign start      = ~cyc_n & ~strb_q;
  assign rd_dir     = (dir == DIR_IN);
  assign rdy_pull   = hit & ~done & ~cyc_n;
  assign rd_req     = hit & rd_dir & ~done & ~cyc_n;
  assign dout_oe    = hit & rd_dir & ~cyc_n;
  assign rd_take    = rd_req & ack;
  assign wr_take    = hit & ~rd_dir & wr_valid & ack & ~cyc_n;
  assign wr_side_en = hit & ~rd_dir & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      hit    <= 1'b0;
      done   <= 1'b0;
      dir    <= DIR_OUT;
    end else begin
      strb_q <= ~cyc_n;
      if (cyc_n) begin
        hit  <= 1'b0;
        done <= 1'b0;
      end else if (start) begin
        hit  <= match_now;
        dir  <= is_read ? DIR_IN : DIR_OUT;
        done <= 1'b0;
      end else if (rd_take || wr_take) begin
        done <= 1'b1;
      end
    end
  end

  // Clocks spent in a matched cycle without the ready line driven.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_cnt <= '0;
    end else if (cyc_n) begin
      late_cnt <= '0;
    end else if (((start && match_now) || hit) && !rdy_pull && !done) begin
      if (late_cnt != CW'(BUDGET + 1)) late_cnt <= late_cnt + 1'b1;
    end
  end

  assert_ready_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
    late_cnt < CW'(BUDGET));

  assert_release_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_n && (rd_take || wr_take)) |=> (!rdy_pull));

  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_n |-> (!rdy_pull && !dout_oe && !rd_req));

  assert_stray_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_n && !start && hit && !done && ack && !rd_req && !wr_valid) |=> (rdy_pull || cyc_n));

endmodule

// File: rtl/pcr_device_responder.sv
module pcr_device_responder
  import pcr_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] DEV_ADDR = 8'h5A,
  parameter int          READY_NS = 625,
  parameter int          CLK_NS   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_n,
  input  logic          dstrb_n,
  input  logic          is_read,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          dout_oe,
  output logic          rdy_pull,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  input  logic [DW-1:0] rd_data,
  input  logic          ack
);

  localparam int READY_BUDGET = budget_clocks(READY_NS, CLK_NS);

  logic match_now;
  logic hit;
  logic rd_dir;
  logic rd_take;
  logic wr_side_en;

  assign match_now = addr_hit(32'(bus_addr), 32'(DEV_ADDR));

  pcr_cycle_ctl #(.BUDGET(READY_BUDGET)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_n      (cyc_n),
    .match_now  (match_now),
    .is_read    (is_read),
    .wr_valid   (wr_valid),
    .ack        (ack),
    .hit        (hit),
    .rd_dir     (rd_dir),
    .rdy_pull   (rdy_pull),
    .dout_oe    (dout_oe),
    .rd_req     (rd_req),
    .rd_take    (rd_take),
    .wr_side_en (wr_side_en)
  );

  pcr_wr_latch #(.DW(DW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_n    (cyc_n),
    .dstrb_n  (dstrb_n),
    .take_en  (wr_side_en),
    .ack      (ack),
    .bus_din  (bus_din),
    .wr_valid (wr_valid),
    .wr_data  (wr_data)
  );

  pcr_rd_hold #(.DW(DW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (rd_take),
    .rd_data (rd_data),
    .q       (bus_dout)
  );

  assert_miss_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |-> (!rdy_pull && !dout_oe && !wr_valid && !rd_req));

  assert_write_only_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (hit && !rd_dir));

  assert_read_data_at_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ack) |=> (bus_dout == $past(rd_data) && !rdy_pull));

endmodule

// File: tb/tb_pcr_device_responder.sv
module tb_pcr_device_responder;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [7:0] DEV = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_n = 1'b1;
  logic dstrb_n = 1'b1;
  logic is_read = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] bus_dout;
  logic dout_oe, rdy_pull, wr_valid, rd_req;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data = '0;
  logic ack = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pcr_device_responder #(.AW(AW), .DW(DW), .DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .dstrb_n(dstrb_n), .is_read(is_read),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .dout_oe(dout_oe),
    .rdy_pull(rdy_pull), .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .ack(ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int waits);
    bit h;
    h = (a == DEV);
    @(negedge clk);
    bus_addr = a; bus_din = d; is_read = 1'b0; cyc_n = 1'b0;
    @(negedge clk);
    chk(rdy_pull == h, "R2 ready pulled after strobe", rdy_pull, h);
    chk(dout_oe == 1'b0, "R6 no drive on output cycle", dout_oe, 0);
    bus_addr = h ? (a + 8'd1) : DEV;   // mid-cycle address change
    ack = 1'b1;                        // nothing pending yet
    @(negedge clk);
    ack = 1'b0;
    chk(rdy_pull == h, "R7 stray ack ignored", rdy_pull, h);
    chk(rdy_pull == h, "R8 late address ignored", rdy_pull, h);
    dstrb_n = 1'b0;
    @(negedge clk);
    dstrb_n = 1'b1;
    chk(wr_valid == h, "R4 wr_valid after strobe", wr_valid, h);
    if (h) chk(wr_data == d, "R4 captured data", wr_data, d);
    chk(wr_valid == h, "R1 miss leaves wr_valid low", wr_valid, h);
    bus_din = ~d;
    @(negedge clk);
    dstrb_n = 1'b0;                    // second strobe
    @(negedge clk);
    dstrb_n = 1'b1;
    if (h) chk(wr_data == d, "R4 second strobe ignored", wr_data, d);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk(rdy_pull == h, "R3 wait state holds ready low", rdy_pull, h);
      chk(wr_valid == h, "R4 wr_valid held until ack", wr_valid, h);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(rdy_pull == 1'b0, "R3 ready released after ack", rdy_pull, 0);
    chk(wr_valid == 1'b0, "R4 wr_valid cleared by ack", wr_valid, 0);
    @(negedge clk);
    chk(rdy_pull == 1'b0, "R3 ready stays released", rdy_pull, 0);
    cyc_n = 1'b1;
    #1;
    chk(rdy_pull == 1'b0 && dout_oe == 1'b0, "R6 released at strobe end", rdy_pull, 0);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] d, input int waits);
    bit h;
    h = (a == DEV);
    @(negedge clk);
    bus_addr = a; is_read = 1'b1; cyc_n = 1'b0;
    @(negedge clk);
    chk(rdy_pull == h, "R2 read ready pulled", rdy_pull, h);
    chk(rd_req == h, "R5 rd_req raised", rd_req, h);
    chk(dout_oe == h, "R6 drive enable on matched read", dout_oe, h);
    chk(dout_oe == h, "R1 miss leaves bus undriven", dout_oe, h);
    bus_addr = h ? (a ^ 8'h01) : DEV;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk(rdy_pull == h && rd_req == h, "R8 read wait state", rdy_pull, h);
    end
    ack = 1'b1; rd_data = d;
    @(negedge clk);
    ack = 1'b0; rd_data = ~d;
    chk(rdy_pull == 1'b0, "R5 ready released with data", rdy_pull, 0);
    chk(rd_req == 1'b0, "R5 rd_req dropped", rd_req, 0);
    if (h) chk(bus_dout == d, "R5 bus data loaded", bus_dout, d);
    cyc_n = 1'b1;
    #1;
    chk(dout_oe == 1'b0 && rd_req == 1'b0, "R6 drive off at strobe end", dout_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy_pull == 0 && dout_oe == 0 && wr_valid == 0 && rd_req == 0,
        "R6 reset state", {rdy_pull, dout_oe, wr_valid, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 256; a++) do_write(8'(a), 8'(a) ^ 8'hC3, a % 4);
    for (int a = 0; a < 256; a++) do_read(8'(a), 8'(a * 7 + 1), (a + 1) % 3);
    do_write(DEV, 8'h00, 6);
    do_read(DEV, 8'hFF, 6);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule